// File: doc/BRIEF.md
# Single-Word Memory Consistency Monitor

This block is a synthesizable checker. It watches two streams at once: a core's retirement trace and the read responses on its data memory bus. It tracks one word of memory, at an address supplied at start-up and held for the whole run. For that word it keeps, byte by byte, the value that a correct core must report. A byte gets its value in one of two ways: from the first non-faulting bus read that returns it, or from a retired store.

Every retired, non-trapping load of the word is compared with that reference. The first disagreement raises a sticky error output one cycle later. Stores never have to appear on the bus, so a write-back cache may sit between the core and the observed bus. A bus fault reported anywhere in the fault granule that holds the word discards the bus-derived bytes, because the line was never legitimately filled. Bytes defined by stores are kept.

Top module: `memword_monitor`

## Requirements
- R1: After reset, `err_o` is 0 and every byte of the watched word is undefined. A retired read of an undefined byte is never compared.
- R2: A non-faulting bus read of the watched word defines each undefined byte selected by `bus_rmask_i` (bit b selects data bits 8b+7:8b). A later retired read whose selected bytes differ from these values sets `err_o` at the next clock edge.
- R3: A bus read of a byte that is already defined leaves its reference unchanged, so stale or newer bus data is not used.
- R4: A retired store defines each byte selected by `ret_wmask_i` with the store data. No bus write is needed. Later retired reads must match these bytes.
- R5: Only bytes selected by `ret_rmask_i` are compared. Bytes outside the mask, and bytes that are still undefined, are never compared.
- R6: A retirement with `ret_trap_i` set is neither compared nor applied.
- R7: Retirements and bus reads whose word address (address bits above log2 of the word size in bytes) differs from that of `watch_addr_i` have no effect.
- R8: A bus response with `bus_fault_i` set, whose address lies in the same FAULT_BYTES-aligned granule as the watched word, makes undefined all bytes last defined by the bus. Bytes last defined by stores keep their values.
- R9: Once set, `err_o` stays 1 until reset.
- R10: A retirement that both reads and writes is compared against the value held before it, and its write then applies. When a store and a bus read target the same byte in one cycle, the store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| watch_addr_i | input | ADDR_W | Address of the watched word, held constant |
| bus_valid_i | input | 1 | A bus read response is present |
| bus_addr_i | input | ADDR_W | Address of the bus read |
| bus_rmask_i | input | DATA_W/8 | Byte lanes returned by the bus read |
| bus_rdata_i | input | DATA_W | Data returned by the bus read |
| bus_fault_i | input | 1 | The bus read faulted |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_trap_i | input | 1 | The retiring instruction trapped |
| ret_addr_i | input | ADDR_W | Memory address of the retiring access |
| ret_rmask_i | input | DATA_W/8 | Bytes read by the retiring access |
| ret_wmask_i | input | DATA_W/8 | Bytes written by the retiring access |
| ret_rdata_i | input | DATA_W | Data the core reports as read |
| ret_wdata_i | input | DATA_W | Data the core reports as written |
| err_o | output | 1 | Sticky consistency error |

## Verification
The bench goes after several corner cases, each with a wrong design in mind:
- Loads that arrive before any fetch, and loads outside the byte mask. A monitor that compared these would flag correct cores.
- A second bus read with different data. A design that refilled the reference from it would miss a real mismatch or report a false one.
- A read-modify-write retirement. An ordering bug would compare against the new value.
- A fault on a neighbouring word of the same granule. If store-derived bytes were dropped, later mismatches would be missed. If bus bytes were kept, a refetch would produce false errors.
- Long random runs with rare corrupted load data. These confirm that the error appears exactly one cycle after the bad retirement and never otherwise.

// File: rtl/memmon_pkg.sv
package memmon_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SRC_BUS   = 1'b0,
    SRC_STORE = 1'b1
  } byte_src_e;
endpackage

// File: rtl/memmon_match.sv
module memmon_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 2
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);
  assign eq_o = (a_i[ADDR_W-1:LSB] == b_i[ADDR_W-1:LSB]);
endmodule

// File: rtl/memmon_lane.sv
module memmon_lane
  import memmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ret_hit_i,
  input  logic              ret_skip_i,
  input  logic              ret_rd_i,
  input  logic              ret_wr_i,
  input  logic [BYTE_W-1:0] ret_rbyte_i,
  input  logic [BYTE_W-1:0] ret_wbyte_i,
  input  logic              bus_hit_i,
  input  logic              bus_flush_i,
  input  logic [BYTE_W-1:0] bus_byte_i,
  output logic              mism_o
);
  logic              valid_q;
  byte_src_e         src_q;
  logic [BYTE_W-1:0] value_q;
  logic              store;

  assign store  = ret_hit_i && ret_wr_i;
  // compare against state held before this cycle's updates
  assign mism_o = ret_hit_i && ret_rd_i && valid_q && (ret_rbyte_i != value_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= SRC_BUS;
      value_q <= '0;
    end else if (store) begin
      valid_q <= 1'b1;
      src_q   <= SRC_STORE;
      value_q <= ret_wbyte_i;
    end else if (bus_flush_i && src_q == SRC_BUS) begin
      valid_q <= 1'b0;
    end else if (bus_hit_i && !valid_q) begin
      valid_q <= 1'b1;
      src_q   <= SRC_BUS;
      value_q <= bus_byte_i;
    end
  end

  AST_STORE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store |=> valid_q && value_q == $past(ret_wbyte_i)); // R4
  AST_FETCH_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_hit_i && !valid_q && !store |=> valid_q && value_q == $past(bus_byte_i)); // R2
  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_hit_i && valid_q && !store && !bus_flush_i |=> valid_q && $stable(value_q)); // R3
  AST_TRAP_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_skip_i && !bus_hit_i && !bus_flush_i |=> $stable(valid_q) && $stable(value_q)); // R6
  AST_FLUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_flush_i && src_q == SRC_BUS && !store |=> !valid_q); // R8
endmodule

// File: rtl/memmon_err.sv
module memmon_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mism_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | mism_i;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R9
endmodule

// File: rtl/memword_monitor.sv
module memword_monitor
  import memmon_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FAULT_BYTES = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        watch_addr_i,
  input  logic                     bus_valid_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W/BYTE_W-1:0] bus_rmask_i,
  input  logic [DATA_W-1:0]        bus_rdata_i,
  input  logic                     bus_fault_i,
  input  logic                     ret_valid_i,
  input  logic                     ret_trap_i,
  input  logic [ADDR_W-1:0]        ret_addr_i,
  input  logic [DATA_W/BYTE_W-1:0] ret_rmask_i,
  input  logic [DATA_W/BYTE_W-1:0] ret_wmask_i,
  input  logic [DATA_W-1:0]        ret_rdata_i,
  input  logic [DATA_W-1:0]        ret_wdata_i,
  output logic                     err_o
);
  localparam int unsigned NB       = DATA_W / BYTE_W;
  localparam int unsigned WORD_LSB = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned GRAN_LSB = (FAULT_BYTES > NB) ? $clog2(FAULT_BYTES) : WORD_LSB;

  logic          ret_word_eq, bus_word_eq, bus_gran_eq;
  logic          ret_hit, ret_skip, bus_hit, bus_flush, mism_any;
  logic [NB-1:0] mism;

  memmon_match #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_ret_word (
    .a_i(ret_addr_i), .b_i(watch_addr_i), .eq_o(ret_word_eq));
  memmon_match #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_bus_word (
    .a_i(bus_addr_i), .b_i(watch_addr_i), .eq_o(bus_word_eq));
  memmon_match #(.ADDR_W(ADDR_W), .LSB(GRAN_LSB)) u_bus_gran (
    .a_i(bus_addr_i), .b_i(watch_addr_i), .eq_o(bus_gran_eq));

  assign ret_hit   = ret_valid_i && !ret_trap_i && ret_word_eq;
  assign ret_skip  = ret_valid_i &&  ret_trap_i && ret_word_eq;
  assign bus_hit   = bus_valid_i && !bus_fault_i && bus_word_eq;
  assign bus_flush = bus_valid_i &&  bus_fault_i && bus_gran_eq;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    memmon_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ret_hit_i   (ret_hit),
      .ret_skip_i  (ret_skip),
      .ret_rd_i    (ret_rmask_i[b]),
      .ret_wr_i    (ret_wmask_i[b]),
      .ret_rbyte_i (ret_rdata_i[b*BYTE_W +: BYTE_W]),
      .ret_wbyte_i (ret_wdata_i[b*BYTE_W +: BYTE_W]),
      .bus_hit_i   (bus_hit && bus_rmask_i[b]),
      .bus_flush_i (bus_flush),
      .bus_byte_i  (bus_rdata_i[b*BYTE_W +: BYTE_W]),
      .mism_o      (mism[b])
    );
  end

  assign mism_any = |mism;

  memmon_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mism_i (mism_any),
    .err_o  (err_o)
  );

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(mism_any)); // R2
  AST_OTHER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && !ret_word_eq |-> !mism_any); // R7
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(watch_addr_i)); // R7
endmodule

// File: tb/tb_memword_monitor.sv
`timescale 1ns/1ps
module tb_memword_monitor;
  localparam logic [31:0] W = 32'h1000_0040;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid = 1'b0, bus_fault = 1'b0, ret_valid = 1'b0, ret_trap = 1'b0;
  logic [31:0] bus_addr = '0, bus_rdata = '0, ret_addr = '0, ret_rdata = '0, ret_wdata = '0;
  logic [3:0]  bus_rmask = '0, ret_rmask = '0, ret_wmask = '0;
  logic        err_o;

  int checks = 0, errors = 0;
  logic [7:0] mv [4];
  bit         mval [4];
  bit         mst [4];
  bit         exp_err;

  always #4 clk = ~clk;

  memword_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni), .watch_addr_i(W),
    .bus_valid_i(bus_valid), .bus_addr_i(bus_addr), .bus_rmask_i(bus_rmask),
    .bus_rdata_i(bus_rdata), .bus_fault_i(bus_fault),
    .ret_valid_i(ret_valid), .ret_trap_i(ret_trap), .ret_addr_i(ret_addr),
    .ret_rmask_i(ret_rmask), .ret_wmask_i(ret_wmask), .ret_rdata_i(ret_rdata),
    .ret_wdata_i(ret_wdata), .err_o(err_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: err_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    bus_valid = 1'b0; ret_valid = 1'b0;
    for (int b = 0; b < 4; b++) begin mval[b] = 0; mst[b] = 0; mv[b] = '0; end
    exp_err = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset", err_o, 1'b0);
  endtask

  // drive one cycle, update model, check err_o one edge later
  task automatic step(input string tag,
                      input bit rv, input bit tr, input [31:0] ra, input [3:0] rm,
                      input [3:0] wm, input [31:0] rd, input [31:0] wd,
                      input bit bv, input bit bf, input [31:0] ba, input [3:0] bm,
                      input [31:0] bd);
    bit rhit, bhit, flush, mism;
    ret_valid = rv; ret_trap = tr; ret_addr = ra; ret_rmask = rm; ret_wmask = wm;
    ret_rdata = rd; ret_wdata = wd;
    bus_valid = bv; bus_fault = bf; bus_addr = ba; bus_rmask = bm; bus_rdata = bd;
    rhit  = rv && !tr && ra[31:2] == W[31:2];
    bhit  = bv && !bf && ba[31:2] == W[31:2];
    flush = bv && bf && ba[31:4] == W[31:4];
    mism  = 0;
    for (int b = 0; b < 4; b++)
      if (rhit && rm[b] && mval[b] && rd[b*8 +: 8] != mv[b]) mism = 1;
    for (int b = 0; b < 4; b++) begin
      if (rhit && wm[b]) begin mval[b] = 1; mst[b] = 1; mv[b] = wd[b*8 +: 8]; end
      else if (flush && !mst[b]) mval[b] = 0;
      else if (bhit && bm[b] && !mval[b]) begin mval[b] = 1; mst[b] = 0; mv[b] = bd[b*8 +: 8]; end
    end
    exp_err = exp_err | mism;
    @(posedge clk);
    @(negedge clk);
    check(tag, err_o, exp_err);
    ret_valid = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic fetch(input string tag, input [31:0] a, input [3:0] m, input [31:0] d);
    step(tag, 0, 0, '0, '0, '0, '0, '0, 1, 0, a, m, d);
  endtask
  task automatic rd(input string tag, input [31:0] a, input [3:0] m, input [31:0] d);
    step(tag, 1, 0, a, m, '0, d, '0, 0, 0, '0, '0, '0);
  endtask
  task automatic wr(input string tag, input [31:0] a, input [3:0] m, input [31:0] d);
    step(tag, 1, 0, a, '0, m, '0, d, 0, 0, '0, '0, '0);
  endtask
  task automatic idle(input string tag);
    step(tag, 0, 0, '0, '0, '0, '0, '0, 0, 0, '0, '0, '0);
  endtask

  function automatic logic [31:0] model_word();
    for (int b = 0; b < 4; b++) model_word[b*8 +: 8] = mval[b] ? mv[b] : 8'($urandom);
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: read before any fetch is not compared
    rd("R1 undefined read", W, 4'hF, 32'hDEAD_BEEF);
    // R2: first fetch defines, mismatch flags next cycle
    fetch("R2 fetch", W, 4'hF, 32'hA1B2_C3D4);
    rd("R2 matching read", W, 4'hF, 32'hA1B2_C3D4);
    rd("R2 mismatch read", W, 4'hF, 32'hA1B2_C3D5);
    // R9: sticky
    idle("R9 sticky 1"); idle("R9 sticky 2");
    rd("R9 sticky after good read", W, 4'hF, 32'hA1B2_C3D4);
    // R3: second fetch ignored
    do_reset();
    fetch("R3 first fetch", W, 4'hF, 32'h1111_1111);
    fetch("R3 second fetch", W, 4'hF, 32'h2222_2222);
    rd("R3 read first value", W, 4'hF, 32'h1111_1111);
    rd("R3 read second value", W, 4'hF, 32'h2222_2222);
    // R4: store without bus write
    do_reset();
    fetch("R4 fetch", W, 4'hF, 32'h0000_0000);
    wr("R4 store", W, 4'hF, 32'h1122_3344);
    rd("R4 read stored", W, 4'hF, 32'h1122_3344);
    rd("R4 read stale bus value", W, 4'hF, 32'h0000_0000);
    // R5: masks and undefined bytes
    do_reset();
    fetch("R5 partial fetch", W, 4'h3, 32'hFFFF_5A6B);
    rd("R5 undefined bytes", W, 4'hC, 32'h1234_0000);
    rd("R5 unmasked garbage", W, 4'h1, 32'h9999_996B);
    rd("R5 masked mismatch", W, 4'h2, 32'h0000_0000);
    // R6: trapped retirements
    do_reset();
    fetch("R6 fetch", W, 4'hF, 32'hCAFE_F00D);
    step("R6 trapped store", 1, 1, W, '0, 4'hF, '0, 32'h0BAD_0BAD, 0, 0, '0, '0, '0);
    step("R6 trapped bad read", 1, 1, W, 4'hF, '0, 32'h0, '0, 0, 0, '0, '0, '0);
    rd("R6 old value holds", W, 4'hF, 32'hCAFE_F00D);
    // R7: other words
    do_reset();
    wr("R7 store other word", W + 4, 4'hF, 32'h7777_7777);
    fetch("R7 fetch other word", W + 8, 4'hF, 32'h5555_5555);
    rd("R7 read watch undefined", W, 4'hF, 32'h0123_4567);
    fetch("R7 fetch watch", W, 4'hF, 32'h8888_8888);
    rd("R7 read other word garbage", W + 4, 4'hF, 32'h0);
    rd("R7 watch still right", W, 4'hF, 32'h8888_8888);
    // R8: granule fault
    do_reset();
    fetch("R8 fetch", W, 4'hF, 32'hAAAA_AAAA);
    wr("R8 store byte0", W, 4'h1, 32'h0000_0055);
    step("R8 fault other granule", 0, 0, '0, '0, '0, '0, '0, 1, 1, W + 16, 4'hF, '0);
    rd("R8 outside granule keeps", W, 4'hF, 32'hAAAA_AA55);
    step("R8 fault same granule", 0, 0, '0, '0, '0, '0, '0, 1, 1, W + 8, 4'hF, '0);
    fetch("R8 refetch", W, 4'hF, 32'hBBBB_BBBB);
    rd("R8 refetched with store byte", W, 4'hF, 32'hBBBB_BB55);
    rd("R8 old bus value now wrong", W, 4'hF, 32'hAAAA_AA55);
    // R10: read-modify-write and store vs fetch
    do_reset();
    fetch("R10 fetch", W, 4'hF, 32'h0000_0010);
    step("R10 rmw", 1, 0, W, 4'hF, 4'hF, 32'h0000_0010, 32'h0000_0011, 0, 0, '0, '0, '0);
    rd("R10 read after rmw", W, 4'hF, 32'h0000_0011);
    do_reset();
    step("R10 store with fetch", 1, 0, W, '0, 4'hF, '0, 32'h4444_4444, 1, 0, W, 4'hF, 32'h9999_9999);
    rd("R10 store won", W, 4'hF, 32'h4444_4444);
    // random phase, mostly-correct data, model-checked
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, ba, d;
      int sel;
      if (i % 300 == 299) do_reset();
      sel = $urandom_range(0, 7);
      ra = (sel < 5) ? W : (sel == 5) ? W + 4 : (sel == 6) ? W + 8 : W + 32;
      sel = $urandom_range(0, 7);
      ba = (sel < 5) ? W : (sel == 5) ? W + 4 : (sel == 6) ? W + 8 : W + 32;
      d = model_word();
      if ($urandom_range(0, 63) == 0) d[$urandom_range(0, 31)] ^= 1'b1;
      step("R2 random", $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0, ra,
           4'($urandom), 4'($urandom_range(0, 3) == 0 ? $urandom : 0), d, $urandom,
           $urandom_range(0, 1) == 1, $urandom_range(0, 11) == 0, ba, 4'($urandom), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule